// File: doc/BRIEF.md
# Radio Serial Command Port and Register File

This block is the command front end of a small radio transceiver. An external controller talks to it through a chip select, a serial clock and one shared data pin. The pin reaches the block as a split pad: an input, an output value and an output enable. The first byte of every select-low period is a command. The command picks one of these actions: a register read or write, a payload transfer, a queue flush, a change to the internal chip-enable state, or a change to what the shared pin carries. Bytes after the command travel most significant bit first. The controller presents each bit before the rising clock edge and reads the block's bits while the clock is high. The block changes its own output bits only after a falling edge.

The pins are sampled with the block's system clock through a synchronizer. All actions therefore happen in that one clock domain. The register file holds the operating mode, the retransmit setup, the channel, the RF setup and the status flags. The block exports decoded controls from these registers: receive/transmit select, power-up, channel and carrier frequency, retransmit delay and limit, and chip enable. The payload queues are not part of the block. It only issues push and pop strobes with byte buses, plus flush pulses. Pin-function commands let the shared pin carry an active-low interrupt level while the chip select is high.

Top module: `radio_spi_ctrl`

## Requirements
- R1: After reset: ce_state=0 and irq_n=1. Pin mode is serial data, with dio_oe=0 while csn is high. Register values are mode 0x08 (prim_rx=0, pwr_up=0), retransmit 0x03, channel 0x02 (rf_freq_mhz=2402) and RF setup 0x0E.
- R2: Command 0x20|a followed by a data byte writes register a. Command 0x00|a returns register a on dio_out as the next byte, MSB first. The addresses are mode 0x00, retransmit 0x04, channel 0x05, RF setup 0x06 and status 0x07. Any other address reads 0x00 and ignores writes. Retransmit bits 7:4 drive retr_delay and bits 3:0 drive retr_limit.
- R3: Mode register bit 0 drives prim_rx (1 = receive) and bit 1 drives pwr_up.
- R4: The channel register only takes values 0x00..0x7D. A larger write leaves it unchanged. rf_freq_mhz equals 2400 plus the channel.
- R5: The status byte is {0, rx-ready (bit 6), tx-done (bit 5), max-retry (bit 4), rx_pipe (bits 3:1), 0}. Writing 1 to bits 6:4 clears those flags. Writing 0 has no effect, and the other bits ignore writes.
- R6: A one-cycle pulse on rx_evt, tx_evt or maxrt_evt sets status bit 6, 5 or 4. irq_n is low while any of the three flags is set.
- R7: After command 0xA0, every following byte gives exactly one tx_push pulse with that byte on tx_data.
- R8: After command 0x61, every following byte is taken from rx_data. One rx_pop pulse is issued once each byte has been fully clocked out.
- R9: Command 0xE1 gives one tx_flush pulse and command 0xE2 gives one rx_flush pulse.
- R10: Command 0x70 sets ce_state to 1 and command 0x71 clears it. The state holds across transactions.
- R11: After command 0x75, the block drives irq_n onto the pin (dio_oe=1) while csn is high. After command 0x74, the pin is released while csn is high.
- R12: Command 0xFF and any unassigned command code return the status byte as the next byte.
- R13: A csn rise in the middle of a byte discards the partial byte. The next select starts a fresh command.
- R14: The block never drives the pin while it is receiving command or write-data bits. It drives only in the byte after a read-type command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the controller |
| dio_in | input | 1 | Shared data pin, input side |
| dio_out | output | 1 | Shared data pin, output value |
| dio_oe | output | 1 | Shared data pin, output enable |
| rx_evt | input | 1 | Pulse: a received packet is ready |
| tx_evt | input | 1 | Pulse: a transmission has completed |
| maxrt_evt | input | 1 | Pulse: the retry limit has been reached |
| rx_pipe | input | 3 | Pipe number at the receive queue head, 7 = empty |
| rx_data | input | 8 | Head byte of the receive queue |
| rx_pop | output | 1 | Pulse: remove the receive head byte |
| tx_data | output | 8 | Byte to append to the transmit queue |
| tx_push | output | 1 | Pulse: append tx_data |
| tx_flush | output | 1 | Pulse: empty the transmit queue |
| rx_flush | output | 1 | Pulse: empty the receive queue |
| ce_state | output | 1 | Internal chip-enable state |
| prim_rx | output | 1 | 1 = receive role, 0 = transmit role |
| pwr_up | output | 1 | Radio powered up |
| rf_chan | output | 7 | Channel number |
| rf_freq_mhz | output | 12 | Carrier frequency in MHz |
| retr_delay | output | 4 | Retransmit delay step |
| retr_limit | output | 4 | Retransmit count limit |
| rf_setup | output | 8 | Stored RF setup byte |
| irq_n | output | 1 | Active-low interrupt level |

## Verification
The assertions assume that csn, sck and dio_in change slowly compared with clk. Each level must last several clock cycles, so every serial edge survives the synchronizer as one clean transition. They also assume that the event inputs are single-cycle pulses. The stimulus keeps both clock phases at eight system clocks and drives data only while sck is low. It holds csn steady for eight clocks around every select change, and it pulses each event input for exactly one cycle. A pin model resolves the shared wire from the controller's and the block's drivers. It counts any cycle in which both drive at once.

// File: rtl/radio_spi_pkg.sv
package radio_spi_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  // opcode classes carried in the top three command bits
  localparam logic [2:0] OP_RD_REG = 3'b000;
  localparam logic [2:0] OP_WR_REG = 3'b001;

  localparam logic [7:0] CMD_RD_PAY  = 8'h61;
  localparam logic [7:0] CMD_WR_PAY  = 8'hA0;
  localparam logic [7:0] CMD_FL_TX   = 8'hE1;
  localparam logic [7:0] CMD_FL_RX   = 8'hE2;
  localparam logic [7:0] CMD_CE_ON   = 8'h70;
  localparam logic [7:0] CMD_CE_OFF  = 8'h71;
  localparam logic [7:0] CMD_PIN_SPI = 8'h74;
  localparam logic [7:0] CMD_PIN_IRQ = 8'h75;

  localparam logic [ADDR_W-1:0] A_MODE = 5'h00;
  localparam logic [ADDR_W-1:0] A_RETR = 5'h04;
  localparam logic [ADDR_W-1:0] A_CHAN = 5'h05;
  localparam logic [ADDR_W-1:0] A_RF   = 5'h06;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h07;

  localparam logic [7:0] RST_MODE = 8'h08;
  localparam logic [7:0] RST_RETR = 8'h03;
  localparam logic [6:0] RST_CHAN = 7'h02;
  localparam logic [7:0] RST_RF   = 8'h0E;

  // index of the lowest flag bit inside the status byte
  localparam int FLAG_LSB = 4;
  localparam int N_FLAGS  = 3;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_RD_REG,
    PH_WR_REG,
    PH_RD_PAY,
    PH_WR_PAY,
    PH_STAT,
    PH_SINK
  } phase_e;

endpackage

// File: rtl/radio_spi_sync.sv
module radio_spi_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_out = stg_q[STAGES-1];

endmodule

// File: rtl/radio_spi_shifter.sv
module radio_spi_shifter
  import radio_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn_s,
  input  logic              sck_s,
  input  logic              din_s,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              load_req,
  output logic              dout
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  logic              sck_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] in_q, in_d;
  logic [BYTE_W-1:0] out_q, out_d;
  logic              pend_q, pend_d;
  logic              rise, fall;

  assign rise = sck_s & ~sck_q & ~csn_s;
  assign fall = ~sck_s & sck_q & ~csn_s;

  assign byte_valid = rise && (cnt_q == CNT_LAST);
  assign rx_byte    = {in_q[BYTE_W-2:0], din_s};
  assign load_req   = fall && pend_q;
  assign dout       = out_q[BYTE_W-1];

  always_comb begin
    cnt_d  = cnt_q;
    in_d   = in_q;
    out_d  = out_q;
    pend_d = pend_q;
    if (csn_s) begin
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (rise) begin
      in_d  = {in_q[BYTE_W-2:0], din_s};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_LAST) pend_d = 1'b1;
    end else if (fall) begin
      if (pend_q) begin
        out_d  = load_byte;
        pend_d = 1'b0;
      end else begin
        out_d = {out_q[BYTE_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      in_q   <= '0;
      out_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      cnt_q  <= cnt_d;
      in_q   <= in_d;
      out_q  <= out_d;
      pend_q <= pend_d;
    end
  end

  // a deselect always leaves the bit position at the start of a byte
  assert_cnt_cleared_R13: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (cnt_q == '0));

  // a completed byte cannot be followed by a load in the very next cycle
  assert_load_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !load_req);

endmodule

// File: rtl/radio_spi_regs.sv
module radio_spi_regs
  import radio_spi_pkg::*;
#(
  parameter int CH_MAX    = 125,
  parameter int FREQ_BASE = 2400,
  parameter int FREQ_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [N_FLAGS-1:0] evt,
  input  logic [2:0]        rx_pipe,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] mode,
  output logic [BYTE_W-1:0] retr,
  output logic [6:0]        chan,
  output logic [BYTE_W-1:0] rf,
  output logic [FREQ_W-1:0] freq_mhz,
  output logic              any_flag
);

  logic [BYTE_W-1:0]  mode_q, mode_d;
  logic [BYTE_W-1:0]  retr_q, retr_d;
  logic [6:0]         chan_q, chan_d;
  logic [BYTE_W-1:0]  rf_q, rf_d;
  logic [N_FLAGS-1:0] flag_q, flag_d;
  logic               wr_stat;

  assign wr_stat = wr_en && (addr == A_STAT);

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    assign flag_d[g] = evt[g] | (flag_q[g] & ~(wr_stat & wdata[FLAG_LSB+g]));
  end

  always_comb begin
    mode_d = mode_q;
    retr_d = retr_q;
    chan_d = chan_q;
    rf_d   = rf_q;
    if (wr_en) begin
      case (addr)
        A_MODE: mode_d = wdata;
        A_RETR: retr_d = wdata;
        A_CHAN: if (int'(wdata) <= CH_MAX) chan_d = wdata[6:0];
        A_RF:   rf_d = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RST_MODE;
      retr_q <= RST_RETR;
      chan_q <= RST_CHAN;
      rf_q   <= RST_RF;
      flag_q <= '0;
    end else begin
      mode_q <= mode_d;
      retr_q <= retr_d;
      chan_q <= chan_d;
      rf_q   <= rf_d;
      flag_q <= flag_d;
    end
  end

  assign status = {1'b0, flag_q, rx_pipe, 1'b0};

  always_comb begin
    case (addr)
      A_MODE:  rd_data = mode_q;
      A_RETR:  rd_data = retr_q;
      A_CHAN:  rd_data = {1'b0, chan_q};
      A_RF:    rd_data = rf_q;
      A_STAT:  rd_data = status;
      default: rd_data = '0;
    endcase
  end

  assign mode     = mode_q;
  assign retr     = retr_q;
  assign chan     = chan_q;
  assign rf       = rf_q;
  assign freq_mhz = FREQ_W'(FREQ_BASE) + FREQ_W'(chan_q);
  assign any_flag = |flag_q;

  assert_chan_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(chan) <= CH_MAX);

  assert_evt_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    evt[N_FLAGS-1] |=> status[FLAG_LSB+N_FLAGS-1]);

  assert_w1c_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wdata[FLAG_LSB+N_FLAGS-1] && !evt[N_FLAGS-1])
      |=> !status[FLAG_LSB+N_FLAGS-1]);

endmodule

// File: rtl/radio_spi_ctrl.sv
module radio_spi_ctrl
  import radio_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CH_MAX      = 125,
  parameter int FREQ_BASE   = 2400,
  parameter int FREQ_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csn,
  input  logic              sck,
  input  logic              dio_in,
  output logic              dio_out,
  output logic              dio_oe,
  input  logic              rx_evt,
  input  logic              tx_evt,
  input  logic              maxrt_evt,
  input  logic [2:0]        rx_pipe,
  input  logic [7:0]        rx_data,
  output logic              rx_pop,
  output logic [7:0]        tx_data,
  output logic              tx_push,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              ce_state,
  output logic              prim_rx,
  output logic              pwr_up,
  output logic [6:0]        rf_chan,
  output logic [FREQ_W-1:0] rf_freq_mhz,
  output logic [3:0]        retr_delay,
  output logic [3:0]        retr_limit,
  output logic [7:0]        rf_setup,
  output logic              irq_n
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  logic [2:0] pins_s;
  logic       csn_s, sck_s, din_s;

  radio_spi_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b101)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int),
    .d_in ({csn, sck, dio_in}),
    .q_out(pins_s)
  );
  assign {csn_s, sck_s, din_s} = pins_s;

  logic              byte_valid, load_req, sh_dout;
  logic [BYTE_W-1:0] rx_byte, load_byte;

  radio_spi_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_int),
    .csn_s     (csn_s),
    .sck_s     (sck_s),
    .din_s     (din_s),
    .load_byte (load_byte),
    .byte_valid(byte_valid),
    .rx_byte   (rx_byte),
    .load_req  (load_req),
    .dout      (sh_dout)
  );

  phase_e            ph_q, ph_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              rdph_q, rdph_d;
  logic              ce_q, ce_d;
  logic              irqm_q, irqm_d;
  logic              wr_en;
  logic              push_q, push_d;
  logic              pop_q, pop_d;
  logic              ftx_q, ftx_d;
  logic              frx_q, frx_d;
  logic [BYTE_W-1:0] txd_q, txd_d;
  logic [BYTE_W-1:0] reg_rd, status, mode, retr;
  logic              any_flag;

  always_comb begin
    ph_d   = ph_q;
    addr_d = addr_q;
    rdph_d = rdph_q;
    ce_d   = ce_q;
    irqm_d = irqm_q;
    wr_en  = 1'b0;
    push_d = 1'b0;
    pop_d  = 1'b0;
    ftx_d  = 1'b0;
    frx_d  = 1'b0;
    txd_d  = txd_q;
    if (csn_s) begin
      ph_d   = PH_CMD;
      rdph_d = 1'b0;
    end else begin
      if (byte_valid) begin
        case (ph_q)
          PH_CMD: begin
            addr_d = rx_byte[ADDR_W-1:0];
            if (rx_byte[7:5] == OP_RD_REG) begin
              ph_d = PH_RD_REG;
            end else if (rx_byte[7:5] == OP_WR_REG) begin
              ph_d = PH_WR_REG;
            end else begin
              ph_d = PH_SINK;
              case (rx_byte)
                CMD_RD_PAY:  ph_d = PH_RD_PAY;
                CMD_WR_PAY:  ph_d = PH_WR_PAY;
                CMD_FL_TX:   ftx_d = 1'b1;
                CMD_FL_RX:   frx_d = 1'b1;
                CMD_CE_ON:   ce_d = 1'b1;
                CMD_CE_OFF:  ce_d = 1'b0;
                CMD_PIN_SPI: irqm_d = 1'b0;
                CMD_PIN_IRQ: irqm_d = 1'b1;
                default:     ph_d = PH_STAT;
              endcase
            end
          end
          PH_WR_REG: wr_en = 1'b1;
          PH_WR_PAY: begin
            push_d = 1'b1;
            txd_d  = rx_byte;
          end
          PH_RD_PAY: pop_d = 1'b1;
          default: ;
        endcase
      end
      if (load_req && (ph_q == PH_RD_REG || ph_q == PH_RD_PAY || ph_q == PH_STAT))
        rdph_d = 1'b1;
    end
  end

  always_comb begin
    case (ph_q)
      PH_RD_REG: load_byte = reg_rd;
      PH_RD_PAY: load_byte = rx_data;
      default:   load_byte = status;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      ph_q   <= PH_CMD;
      addr_q <= '0;
      rdph_q <= 1'b0;
      ce_q   <= 1'b0;
      irqm_q <= 1'b0;
      push_q <= 1'b0;
      pop_q  <= 1'b0;
      ftx_q  <= 1'b0;
      frx_q  <= 1'b0;
      txd_q  <= '0;
    end else begin
      ph_q   <= ph_d;
      addr_q <= addr_d;
      rdph_q <= rdph_d;
      ce_q   <= ce_d;
      irqm_q <= irqm_d;
      push_q <= push_d;
      pop_q  <= pop_d;
      ftx_q  <= ftx_d;
      frx_q  <= frx_d;
      txd_q  <= txd_d;
    end
  end

  radio_spi_regs #(
    .CH_MAX   (CH_MAX),
    .FREQ_BASE(FREQ_BASE),
    .FREQ_W   (FREQ_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_int),
    .wr_en   (wr_en),
    .addr    (addr_q),
    .wdata   (rx_byte),
    .evt     ({rx_evt, tx_evt, maxrt_evt}),
    .rx_pipe (rx_pipe),
    .rd_data (reg_rd),
    .status  (status),
    .mode    (mode),
    .retr    (retr),
    .chan    (rf_chan),
    .rf      (rf_setup),
    .freq_mhz(rf_freq_mhz),
    .any_flag(any_flag)
  );

  assign irq_n      = ~any_flag;
  assign dio_oe     = csn_s ? irqm_q : rdph_q;
  assign dio_out    = csn_s ? irq_n : sh_dout;
  assign ce_state   = ce_q;
  assign prim_rx    = mode[0];
  assign pwr_up     = mode[1];
  assign retr_delay = retr[7:4];
  assign retr_limit = retr[3:0];
  assign tx_push    = push_q;
  assign tx_data    = txd_q;
  assign rx_pop     = pop_q;
  assign tx_flush   = ftx_q;
  assign rx_flush   = frx_q;

  assert_quiet_in_cmd_R14: assert property (@(posedge clk) disable iff (!rst_int)
    (!csn_s && ph_q == PH_CMD) |-> !dio_oe);

  assert_single_strobe_R9: assert property (@(posedge clk) disable iff (!rst_int)
    $onehot0({tx_push, rx_pop, tx_flush, rx_flush}));

  assert_flush_pulse_R9: assert property (@(posedge clk) disable iff (!rst_int)
    tx_flush |=> !tx_flush);

  assert_ce_held_R10: assert property (@(posedge clk) disable iff (!rst_int)
    csn_s |=> $stable(ce_state));

endmodule

// File: tb/radio_spi_ctrl_bench.sv
module radio_spi_ctrl_bench;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csn = 1'b1;
  logic       sck = 1'b0;
  logic       m_drv = 1'b0;
  logic       m_bit = 1'b0;
  logic       pin;
  logic       dio_out, dio_oe;
  logic       rx_evt = 1'b0, tx_evt = 1'b0, maxrt_evt = 1'b0;
  logic [2:0] rx_pipe = 3'b111;
  logic [7:0] rxq;
  logic       rx_pop, tx_push, tx_flush, rx_flush;
  logic [7:0] tx_data;
  logic       ce_state, prim_rx, pwr_up, irq_n;
  logic [6:0] rf_chan;
  logic [11:0] rf_freq_mhz;
  logic [3:0] retr_delay, retr_limit;
  logic [7:0] rf_setup;

  int checks = 0;
  int errors = 0;
  int clash_n = 0;
  int push_n = 0, pop_n = 0, ftx_n = 0, frx_n = 0;
  logic [7:0] push_log [8];
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign pin = m_drv ? m_bit : (dio_oe ? dio_out : 1'b1);

  radio_spi_ctrl u_radio_spi_ctrl (
    .clk(clk), .rst_n(rst_n), .csn(csn), .sck(sck), .dio_in(pin),
    .dio_out(dio_out), .dio_oe(dio_oe), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .maxrt_evt(maxrt_evt), .rx_pipe(rx_pipe), .rx_data(rxq), .rx_pop(rx_pop),
    .tx_data(tx_data), .tx_push(tx_push), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .ce_state(ce_state), .prim_rx(prim_rx), .pwr_up(pwr_up), .rf_chan(rf_chan),
    .rf_freq_mhz(rf_freq_mhz), .retr_delay(retr_delay), .retr_limit(retr_limit),
    .rf_setup(rf_setup), .irq_n(irq_n)
  );

  // receive queue model and strobe monitors
  always @(posedge clk) begin
    if (!rst_n) rxq <= 8'h40;
    else if (rx_pop) rxq <= rxq + 8'd1;
    if (rst_n) begin
      if (rx_pop) pop_n++;
      if (tx_flush) ftx_n++;
      if (rx_flush) frx_n++;
      if (tx_push) begin
        if (push_n < 8) push_log[push_n] = tx_data;
        push_n++;
      end
      if (m_drv && dio_oe) clash_n++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    wait_clk(1); csn = 1'b0; wait_clk(H);
  endtask

  task automatic desel();
    wait_clk(H); csn = 1'b1; wait_clk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_drv = 1'b1; m_bit = b[i];
      wait_clk(H); sck = 1'b1;
      wait_clk(H); sck = 1'b0;
    end
    m_drv = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      wait_clk(H); sck = 1'b1;
      wait_clk(H/2); v[i] = pin;
      wait_clk(H/2); sck = 1'b0;
    end
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [7:0] d);
    sel(); send_bits({3'b001, a}, 8); send_bits(d, 8); desel();
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [7:0] v);
    sel(); send_bits({3'b000, a}, 8); recv_byte(v); desel();
  endtask

  task automatic cmd_only(input logic [7:0] c);
    sel(); send_bits(c, 8); desel();
  endtask

  task automatic cmd_status(input logic [7:0] c, output logic [7:0] v);
    sel(); send_bits(c, 8); recv_byte(v); desel();
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: rx_evt = 1'b1;
      1: tx_evt = 1'b1;
      default: maxrt_evt = 1'b1;
    endcase
    @(negedge clk);
    rx_evt = 1'b0; tx_evt = 1'b0; maxrt_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ce_state", ce_state, 0);
    chk("R1 irq_n", irq_n, 1);
    chk("R1 prim_rx", prim_rx, 0);
    chk("R1 pwr_up", pwr_up, 0);
    chk("R1 freq", rf_freq_mhz, 2402);
    chk("R1 dio_oe", dio_oe, 0);
    chk("R1 retr_limit", retr_limit, 3);
    chk("R1 rf_setup", rf_setup, 8'h0E);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    reg_rd(5'h00, v); chk("R1 mode reset read", v, 8'h08);
    reg_wr(5'h00, 8'h03);
    chk("R3 prim_rx set", prim_rx, 1);
    chk("R3 pwr_up set", pwr_up, 1);
    reg_rd(5'h00, v); chk("R2 mode readback", v, 8'h03);
    reg_wr(5'h00, 8'h02);
    chk("R3 prim_rx clear", prim_rx, 0);
    chk("R3 pwr_up kept", pwr_up, 1);
    reg_wr(5'h04, 8'hA5);
    chk("R2 retr_delay", retr_delay, 4'hA);
    chk("R2 retr_limit", retr_limit, 4'h5);
    reg_rd(5'h04, v); chk("R2 retr readback", v, 8'hA5);
    reg_wr(5'h06, 8'h3C);
    reg_rd(5'h06, v); chk("R2 rf readback", v, 8'h3C);
    reg_wr(5'h09, 8'hAA);
    reg_rd(5'h09, v); chk("R2 unmapped reads zero", v, 8'h00);
  endtask

  task automatic t_chan();
    logic [7:0] v;
    reg_wr(5'h05, 8'h28); chk("R4 freq 2440", rf_freq_mhz, 2440);
    reg_wr(5'h05, 8'h7E); chk("R4 out-of-range ignored", rf_chan, 7'h28);
    reg_wr(5'h05, 8'h7D); chk("R4 top channel", rf_freq_mhz, 2525);
    reg_rd(5'h05, v);     chk("R4 chan readback", v, 8'h7D);
  endtask

  task automatic t_status();
    logic [7:0] v;
    cmd_status(8'hFF, v); chk("R12 nop idle status", v, 8'h0E);
    pulse(0); pulse(1);
    wait_clk(2); chk("R6 irq asserted", irq_n, 0);
    cmd_status(8'hFF, v); chk("R5 R6 status flags", v, 8'h6E);
    reg_wr(5'h07, 8'h2F);
    reg_rd(5'h07, v); chk("R5 w1c tx flag only", v, 8'h4E);
    pulse(2);
    cmd_status(8'h50, v); chk("R12 unassigned cmd status", v, 8'h5E);
    rx_pipe = 3'b010;
    reg_wr(5'h07, 8'hFF);
    reg_rd(5'h07, v); chk("R5 all clear pipe 2", v, 8'h04);
    chk("R6 irq released", irq_n, 1);
    rx_pipe = 3'b111;
  endtask

  task automatic t_pay_wr();
    int base = push_n;
    sel(); send_bits(8'hA0, 8);
    send_bits(8'h11, 8); send_bits(8'hC3, 8); send_bits(8'h7E, 8);
    desel();
    chk("R7 push count", push_n - base, 3);
    chk("R7 byte 0", push_log[base], 8'h11);
    chk("R7 byte 2", push_log[base+2], 8'h7E);
  endtask

  task automatic t_pay_rd();
    logic [7:0] a, b;
    int base = pop_n;
    sel(); send_bits(8'h61, 8); recv_byte(a); recv_byte(b); desel();
    chk("R8 first byte", a, 8'h40);
    chk("R8 second byte", b, 8'h41);
    chk("R8 pop count", pop_n - base, 2);
  endtask

  task automatic t_flush();
    cmd_only(8'hE1);
    chk("R9 tx flush once", ftx_n, 1);
    chk("R9 rx untouched", frx_n, 0);
    cmd_only(8'hE2);
    chk("R9 rx flush once", frx_n, 1);
  endtask

  task automatic t_ce();
    cmd_only(8'h70); chk("R10 ce on", ce_state, 1);
    reg_wr(5'h06, 8'h01); chk("R10 ce held", ce_state, 1);
    cmd_only(8'h71); chk("R10 ce off", ce_state, 0);
  endtask

  task automatic t_pin();
    logic [7:0] v;
    pulse(0);
    cmd_only(8'h75);
    chk("R11 irq mode drives", dio_oe, 1);
    chk("R11 pin low on flag", pin, 0);
    reg_wr(5'h07, 8'h70);
    chk("R11 pin high after clear", pin, 1);
    reg_rd(5'h05, v); chk("R11 serial works in irq mode", v, 8'h7D);
    cmd_only(8'h74);
    chk("R11 released", dio_oe, 0);
  endtask

  task automatic t_abort();
    logic [7:0] v;
    reg_wr(5'h06, 8'h0E);
    sel(); send_bits(8'h26, 8); send_bits(8'h55, 4); desel();
    reg_rd(5'h06, v); chk("R13 partial write dropped", v, 8'h0E);
    sel(); send_bits(8'hA0, 5); desel();
    reg_wr(5'h06, 8'h3F);
    reg_rd(5'h06, v); chk("R13 fresh command after abort", v, 8'h3F);
  endtask

  initial begin
    wait_clk(5); rst_n = 1'b1; wait_clk(6);
    t_reset();
    t_regs();
    t_chan();
    t_status();
    t_pay_wr();
    t_pay_rd();
    t_flush();
    t_ce();
    t_pin();
    t_abort();
    chk("R14 no pin contention", clash_n, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule